// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable model of a single-cycle-deselect synchronous burst SRAM. It holds a word array built from byte lanes. It registers every control and the address on the rising clock edge, and it returns read data either through an output register (pipeline mode) or straight from the array (flow-through mode). A static mode input selects between the two.

A cycle is opened by one of two address strobes. The processor strobe always starts a read, and it is ignored while its masking enable is high. The controller strobe starts a read or a write, as the write controls decide. Once a cycle is open, the cycles that follow without a strobe either advance a two-bit burst counter or hold the current address. The counter runs in linear or interleaved order and wraps after four beats. A write can cover all lanes (global write) or only the lanes selected by the per-lane enables (byte write). It is committed on the edge that samples it.

The output enable acts at once and only gates the output drivers. A read cycle taken with the output enable high (a dummy read) still moves the burst along. A dummy read lets a write follow a read directly, without a deselect cycle in between.

Top module: `sync_burst_sram`

## Requirements
- R1: The chip counts as enabled only when sel_hi=1, sel_n=0 and sel_n_mask=0. A strobe sampled with any other combination opens a deselect cycle, and dq_drive is 0 in the output slot that belongs to it.
- R2: While sel_n_mask=1, pstrb_n is ignored. The cycle is then decided by cstrb_n and adv_n alone: an active burst goes on, and an idle core stays idle.
- R3: Write decode. gwr_n=0 writes every lane. Otherwise, bwr_n=0 writes only the lanes i with lane_wr_n[i]=0, where lane i is wdata bits [i*LANE_W +: LANE_W]. In every other case the cycle is a read, and bwr_n=0 with no lane selected is a read as well.
- R4: An enabled cycle opened by pstrb_n=0 is a read, whatever the write controls. This holds even when cstrb_n is also 0. A cycle opened by cstrb_n=0 with pstrb_n=1 is a read or a write according to R3.
- R5: With both strobes high and a burst active, adv_n=0 moves the beat count on by one and adv_n=1 holds it. The low two address bits are (start+beat) mod 4 when linear_order=1 and start XOR beat when linear_order=0. The upper bits stay fixed, and the fifth address of a burst equals the first.
- R6: With pipe_mode=1, data read in the cycle registered at edge k is driven from edge k+1 until edge k+2.
- R7: With pipe_mode=0, data read in the cycle registered at edge k is driven from edge k until edge k+1.
- R8: dq_drive is 1 only while oe_n=0 and the current output slot carries read data. oe_n acts without waiting for a clock edge.
- R9: A read taken with oe_n=1 advances the burst exactly like a driven read, and a controller write may follow it in the very next cycle.
- R10: Deselect takes a single cycle, and the core stays idle after it until a strobe opens a new cycle.
- R11: A write is committed at the edge that samples it. A read of the same word in the next cycle returns the new data.
- R12: rst_n=0 clears the control state, so dq_drive is 0 after reset. The array contents are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset of the control state, active low |
| pipe_mode | input | 1 | 1 selects the registered output, 0 selects flow-through |
| linear_order | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sel_n_mask | input | 1 | Active-low enable that also masks pstrb_n |
| sel_hi | input | 1 | Active-high enable, sampled with a strobe |
| sel_n | input | 1 | Active-low enable, sampled with a strobe |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte write, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, zero while not driven |
| dq_drive | output | 1 | High when the data drivers are on |

## Verification
The bench builds the core with ADDR_W=5, LANES=2 and LANE_W=8. At this size it can write and read back all 32 words in both output modes. It also sweeps every lane mask under byte write and global write, every starting offset of a burst in both orders (wrap and suspend included), and all eight enable combinations under each strobe. Every cycle is compared against a reference array in the bench and a cycle model derived from the requirements, so any latency or drive error in either mode shows up at the slot where it occurs.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pipe_mode,
  input  logic                      linear_order,
  input  logic                      oe_n,
  input  logic                      sel_n_mask,
  input  logic                      sel_hi,
  input  logic                      sel_n,
  input  logic                      pstrb_n,
  input  logic                      cstrb_n,
  input  logic                      adv_n,
  input  logic                      gwr_n,
  input  logic                      bwr_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic                      dq_drive
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_IDLE, OP_RD, OP_WR} op_t;

  logic [DW-1:0]     mem [DEPTH];
  op_t               cur_op, nxt_op;
  logic [ADDR_W-1:0] start_q, nxt_start, cur_addr, nxt_addr;
  logic [1:0]        beat_q, nxt_beat, nxt_off;
  logic [DW-1:0]     pipe_q;
  logic              pipe_vld;

  wire p_take  = !pstrb_n && !sel_n_mask;
  wire strobe  = p_take || !cstrb_n;
  wire chip_on = sel_hi && !sel_n && !sel_n_mask;
  wire wr_req  = !gwr_n || (!bwr_n && !(&lane_wr_n));
  wire [LANES-1:0] lane_sel = !gwr_n ? {LANES{1'b1}} : ~lane_wr_n;

  always_comb begin
    nxt_op    = cur_op;
    nxt_start = start_q;
    nxt_beat  = beat_q;
    if (strobe) begin
      nxt_start = addr;
      nxt_beat  = 2'd0;
      if (!chip_on)    nxt_op = OP_IDLE;
      else if (p_take) nxt_op = OP_RD;
      else             nxt_op = wr_req ? OP_WR : OP_RD;
    end else if (cur_op != OP_IDLE) begin
      if (!adv_n) nxt_beat = beat_q + 2'd1;
      nxt_op = wr_req ? OP_WR : OP_RD;
    end
  end

  assign nxt_off  = linear_order ? nxt_start[1:0] + nxt_beat : nxt_start[1:0] ^ nxt_beat;
  assign nxt_addr = {nxt_start[ADDR_W-1:2], nxt_off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_op   <= OP_IDLE;
      start_q  <= '0;
      beat_q   <= '0;
      cur_addr <= '0;
      pipe_vld <= 1'b0;
      pipe_q   <= '0;
    end else begin
      cur_op   <= nxt_op;
      start_q  <= nxt_start;
      beat_q   <= nxt_beat;
      cur_addr <= nxt_addr;
      pipe_vld <= (cur_op == OP_RD);
      pipe_q   <= mem[cur_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && nxt_op == OP_WR) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_sel[l]) mem[nxt_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  wire          slot_vld  = pipe_mode ? pipe_vld : (cur_op == OP_RD);
  wire [DW-1:0] slot_data = pipe_mode ? pipe_q : mem[cur_addr];

  assign dq_drive = slot_vld && !oe_n;
  assign dq_out   = dq_drive ? slot_data : '0;
endmodule

module sync_burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic pipe_mode,
  input logic oe_n,
  input logic sel_n_mask,
  input logic sel_hi,
  input logic sel_n,
  input logic pstrb_n,
  input logic cstrb_n,
  input logic gwr_n,
  input logic dq_drive
);
  wire off_strobe = !cstrb_n && (!sel_hi || sel_n || sel_n_mask);
  wire p_open     = !pstrb_n && !sel_n_mask && sel_hi && !sel_n;

  a_r8_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> !oe_n);

  a_r1_deselect_flow: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && off_strobe) |=> !dq_drive);

  a_r1_deselect_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && off_strobe) |=> ##1 !dq_drive);

  a_r4_pstrb_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && p_open) |=> (dq_drive || oe_n));

  a_r11_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && pstrb_n && !cstrb_n && !gwr_n) |=> !dq_drive);

  a_r12_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !dq_drive);
endmodule

bind sync_burst_sram sync_burst_sram_chk u_chk (.*);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  localparam int AW = 5, NL = 2, LW = 8, DW = NL * LW, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, pipe_mode = 0, linear_order = 1, oe_n = 0;
  logic sel_n_mask = 0, sel_hi = 1, sel_n = 0, pstrb_n = 1, cstrb_n = 1, adv_n = 1;
  logic gwr_n = 1, bwr_n = 1;
  logic [NL-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, dq_out;
  logic dq_drive;

  sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (.*);

  always #4 clk = ~clk;

  logic [DW-1:0] ref_mem [DEPTH];
  int m_op = 0, m_start = 0, m_beat = 0;
  bit prev_vld = 0;
  logic [DW-1:0] prev_dat = '0;
  int n_chk = 0, n_fail = 0;
  string req = "R12";
  bit finished = 0;

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'((a * 16'h0101) ^ (salt * 16'h1357) ^ 16'h5A3C);
  endfunction

  function automatic int m_addr();
    int off = linear_order ? ((m_start + m_beat) & 3) : ((m_start ^ m_beat) & 3);
    return (m_start & ~3) | off;
  endfunction

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit p, s, on, w, f_vld, e_vld;
    logic [DW-1:0] f_dat, e_dat;
    p  = !pstrb_n && !sel_n_mask;
    s  = p || !cstrb_n;
    on = sel_hi && !sel_n && !sel_n_mask;
    w  = !gwr_n || (!bwr_n && lane_wr_n != '1);
    if (!rst_n) m_op = 0;
    else if (s) begin
      if (!on) m_op = 0;
      else begin m_start = addr; m_beat = 0; m_op = p ? 1 : (w ? 2 : 1); end
    end else if (m_op != 0) begin
      if (!adv_n) m_beat = (m_beat + 1) % 4;
      m_op = w ? 2 : 1;
    end
    if (rst_n && m_op == 2)
      for (int l = 0; l < NL; l++)
        if (!gwr_n || !lane_wr_n[l]) ref_mem[m_addr()][l*LW +: LW] = wdata[l*LW +: LW];
    @(posedge clk); #1;
    f_vld = rst_n && m_op == 1;
    f_dat = ref_mem[m_addr()];
    e_vld = pipe_mode ? prev_vld : f_vld;
    e_dat = pipe_mode ? prev_dat : f_dat;
    check(req, int'(dq_drive), int'(e_vld && !oe_n));
    if (e_vld && !oe_n) check(req, int'(dq_out), int'(e_dat));
    prev_vld = f_vld;
    prev_dat = f_dat;
  endtask

  task automatic idle_in();
    pstrb_n = 1; cstrb_n = 1; adv_n = 1; gwr_n = 1; bwr_n = 1; lane_wr_n = '1;
    sel_n_mask = 0; sel_hi = 1; sel_n = 0;
  endtask

  task automatic deselect();
    idle_in(); cstrb_n = 0; sel_hi = 0; tick(); idle_in();
  endtask

  task automatic prd(int a);
    idle_in(); pstrb_n = 0; addr = AW'(a); tick(); idle_in();
  endtask

  task automatic crd(int a);
    idle_in(); cstrb_n = 0; addr = AW'(a); tick(); idle_in();
  endtask

  task automatic cwr(int a, logic [DW-1:0] d, bit gw, bit bw, logic [NL-1:0] lanes);
    idle_in(); cstrb_n = 0; addr = AW'(a); wdata = d;
    gwr_n = !gw; bwr_n = !bw; lane_wr_n = lanes; tick(); idle_in();
  endtask

  task automatic adv(bit go);
    idle_in(); adv_n = !go; tick(); idle_in();
  endtask

  task automatic set_mode(bit pm, bit lin);
    deselect(); tick(); tick();
    pipe_mode = pm; linear_order = lin;
    tick();
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    wrap_up();
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
    idle_in();
    req = "R12"; tick(); tick();
    rst_n = 1; tick();

    req = "R11";
    for (int a = 0; a < DEPTH; a++) cwr(a, pat(a, 0), 1, 0, '1);
    deselect();
    req = "R7";
    for (int a = 0; a < DEPTH; a++) prd(a);
    set_mode(1, 1);
    req = "R6";
    for (int a = 0; a < DEPTH; a++) prd(a);
    tick(); set_mode(0, 1);

    req = "R3";
    for (int m = 0; m < 4; m++) begin
      cwr(m, pat(m, 7 + m), 0, 1, NL'(m)); crd(m); adv(0);
      cwr(m + 4, pat(m, 11), 1, 1, NL'(m)); crd(m + 4);
      cwr(m + 8, pat(m, 13), 0, 0, NL'(m)); crd(m + 8);
    end
    req = "R11";
    cwr(20, pat(20, 3), 1, 0, '1); crd(20);

    req = "R4";
    idle_in(); pstrb_n = 0; gwr_n = 0; addr = 5'd21; wdata = 16'hDEAD; tick();
    idle_in(); pstrb_n = 0; cstrb_n = 0; gwr_n = 0; addr = 5'd22; wdata = 16'hBEEF; tick();
    crd(21); crd(22);

    req = "R5";
    for (int pm = 0; pm < 2; pm++)
      for (int lin = 0; lin < 2; lin++) begin
        set_mode(pm[0], lin[0]);
        for (int s = 0; s < 4; s++) begin
          prd(12 + s);
          for (int k = 0; k < 4; k++) adv(1);
          adv(0); adv(0); adv(1);
          req = "R10"; deselect(); tick(); tick(); req = "R5";
        end
        cwr(16 + lin * 2, pat(pm, 5), 1, 0, '1);
        idle_in(); adv_n = 0; gwr_n = 0; wdata = pat(pm, 6); tick();
        idle_in(); adv_n = 0; gwr_n = 0; wdata = pat(pm, 8); tick();
        idle_in();
        prd(16 + lin * 2); adv(1); adv(1); adv(1); tick();
      end
    set_mode(0, 1);

    req = "R1";
    for (int c = 0; c < 8; c++) begin
      idle_in(); sel_n_mask = c[0]; sel_hi = c[1]; sel_n = c[2]; cstrb_n = 0; addr = 5'd3; tick();
      idle_in(); tick(); deselect();
      idle_in(); sel_n_mask = c[0]; sel_hi = c[1]; sel_n = c[2]; pstrb_n = 0; addr = 5'd4; tick();
      idle_in(); tick(); deselect();
    end

    req = "R2";
    prd(24);
    idle_in(); sel_n_mask = 1; pstrb_n = 0; adv_n = 0; addr = 5'd2; tick();
    idle_in(); sel_n_mask = 1; pstrb_n = 0; adv_n = 1; addr = 5'd2; tick();
    deselect();
    idle_in(); sel_n_mask = 1; pstrb_n = 0; addr = 5'd2; tick(); tick();
    idle_in();

    req = "R9";
    oe_n = 1; prd(28); adv(1); adv(1); oe_n = 0; adv(1);
    oe_n = 1; prd(25); cwr(26, pat(26, 9), 1, 0, '1); oe_n = 0; crd(26);
    deselect();

    req = "R8";
    prd(9);
    #1 oe_n = 1; #1 check("R8", int'(dq_drive), 0);
    oe_n = 0; #1 check("R8", int'(dq_drive), 1);
    deselect(); tick();

    req = "R12";
    prd(12); adv(1);
    rst_n = 0; tick(); rst_n = 1; tick();
    check("R12", int'(dq_drive), 0);
    prd(13); prd(20); tick();

    wrap_up();
  end
endmodule